// File: doc/BRIEF.md
# Core Idle Power State Sequencer

This block walks one processor core between the running state C0 and six progressively deeper idle states, C1 through C6, and back again. Software presents a target depth on a 3-bit input. The sequencer enters that depth one step at a time. Each step either changes an output for good, waits on a done handshake from a cache-flush or state-save engine, or waits a counted settling time. Deeper states give lower power and take longer to enter and leave. A retention voltage ramp takes roughly a microsecond. Dropping below retention and recovering takes on the order of 100 µs. PLL relock takes about 15 µs. All of these are cycle counts derived from a clock-frequency parameter and three nanosecond parameters.

The entry steps, in order, are:

- Halt execution (C1).
- Gate the core clock (C2).
- Flush L1, then stop the PLL (C3).
- Partially flush L2, then ramp to retention voltage (C4).
- Ramp to deep retention voltage (C5).
- Save architectural state, fully flush L2, then ramp below retention (C6).

Exit reverses these steps. It raises the voltage, restarts the PLL and waits for lock, restores state, ungates the clock and finally releases the halt. Steps that were never taken are skipped.

Snoops are answered, and interrupts latched, in every state except C6. An interrupt, or a target shallower than the level being held or entered, starts the exit. The controller always returns to C0 before entering a new depth.

States and transitions:

- **Resting states:** RUN, C1, C2, C3, C4, C5, C6. Each one moves deeper when the target is deeper, and moves to the first needed exit step on a wake.
- **Entry steps:**
  - L1FL (flush handshake).
  - L2PFL (partial flush handshake).
  - VRET (retention ramp).
  - VDEEP (deep ramp).
  - SAVE (save handshake).
  - L2FFL (full flush handshake).
  - VOFF (off ramp).
- **Exit steps:**
  - XVUP (voltage ramp up).
  - XPLL (PLL lock wait).
  - XREST (restore handshake).
  - XUNG (one cycle with the clock running and execution still halted).

Top module: `cidle_seq`

## Requirements
- R1: After reset `idle_level`=0, `exec_halt`=0, `clk_gate`=0, `pll_en`=1, `vlevel`=0 and every engine request is 0. `idle_level` shows the resting level last reached (0..6), and a `target_level` of 7 is treated as 6.
- R2: In C1 only `exec_halt` is 1. In C2 `clk_gate` is also 1 and the PLL stays enabled.
- R3: Going from C2 to C3, `l1_flush_req` is held until `l1_flush_done`, and only then does `pll_en` fall.
- R4: Going to C4, a partial L2 flush handshake completes, then `vlevel` becomes 1 (retention) for VRAMP cycles before C4 is reached. In C5 `vlevel`=2, and the step from 1 to 2 is VRAMP+1 cycles.
- R5: Going to C6, `save_req` and then `l2_full_flush_req` complete their handshakes, and then `vlevel` becomes 3. C6 is reported exactly VOFF cycles later. In C6 `snoop_accept` and `irq_accept` are 0.
- R6: On exit, `vlevel` returns to 0 first. `pll_en` rises after VOFF cycles (from level 3) or VRAMP cycles (otherwise). `restore_req` rises exactly PLL cycles later (C6 only), and then `clk_gate` falls. `exec_halt` falls one cycle after `clk_gate` falls. From C3 with no voltage change, `clk_gate` falls exactly PLL cycles after `pll_en` rises.
- R7: Outside C6, a `snoop_req` pulse gives `snoop_ack`=1 on the next cycle, and the level is unchanged. In C6 no `snoop_ack` is given.
- R8: A wake that arrives during a handshake step takes effect when that step's done arrives: no later request is issued and the exit begins, restoring state if it was saved. A wake during a voltage ramp exits at once, and the deeper level is never reported.
- R9: An `irq_in` pulse, or a target below the current level, in any idle state returns the core to C0 (`idle_level`=0). The sequencer then re-enters toward the current target.
- R10: At most one of the five engine requests is active at any time. A clock-gated core is always halted, and a stopped PLL implies a gated clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| target_level | input | 3 | Requested idle depth, 0 = run, values above 6 act as 6 |
| irq_in | input | 1 | Interrupt event |
| snoop_req | input | 1 | Snoop request pulse |
| l1_flush_done | input | 1 | L1 flush engine done pulse |
| l2_part_flush_done | input | 1 | Partial L2 flush done pulse |
| l2_full_flush_done | input | 1 | Full L2 flush done pulse |
| save_done | input | 1 | State save done pulse |
| restore_done | input | 1 | State restore done pulse |
| exec_halt | output | 1 | Stop instruction execution |
| clk_gate | output | 1 | Gate the core clock |
| pll_en | output | 1 | Core PLL enable |
| vlevel | output | 2 | Voltage request: 0 nominal, 1 retention, 2 deep retention, 3 below retention |
| l1_flush_req | output | 1 | Request L1 flush into L2 |
| l2_part_flush_req | output | 1 | Request partial L2 flush |
| l2_full_flush_req | output | 1 | Request full L2 flush |
| save_req | output | 1 | Request architectural state save |
| restore_req | output | 1 | Request architectural state restore |
| snoop_accept | output | 1 | Snoops are being serviced |
| irq_accept | output | 1 | Interrupts are being latched |
| snoop_ack | output | 1 | Snoop answered |
| idle_level | output | 3 | Resting idle level last reached |

## Verification
The hardest situations to reach are the aborts in the middle of a step. One is a wake that lands while the save handshake is still outstanding, where the full flush must never start yet a restore must still happen. The other is a target drop during the short retention ramp, where C4 must never be reported. The bench gets there by polling the request and voltage outputs every cycle. It holds the engine's done pulse back for a few cycles and changes the target in the cycle the step is first seen. Randomized targets, engine delays and interrupt pulses then cover the wake and re-entry paths between arbitrary pairs of depths.

// File: rtl/cidle_pkg.sv
package cidle_pkg;

    localparam int unsigned LVL_W     = 3;
    localparam int unsigned MAX_LEVEL = 6;

    typedef enum logic [4:0] {
        ST_RUN, ST_C1, ST_C2, ST_L1FL, ST_C3, ST_L2PFL, ST_VRET, ST_C4,
        ST_VDEEP, ST_C5, ST_SAVE, ST_L2FFL, ST_VOFF, ST_C6,
        ST_XVUP, ST_XPLL, ST_XREST, ST_XUNG
    } seq_state_e;

    typedef enum logic [1:0] {
        V_NOM  = 2'd0,
        V_RET  = 2'd1,
        V_DEEP = 2'd2,
        V_OFF  = 2'd3
    } volt_e;

    // Conditions the core has been placed in; exit undoes them in order.
    typedef struct packed {
        logic  halted;
        logic  gated;
        logic  pll_off;
        logic  saved;
        volt_e volt;
    } core_cond_t;

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cidle_timer.sv
module cidle_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0)); // R6

endmodule

// File: rtl/cidle_events.sv
module cidle_events (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic snoop_req,
    input  logic accept_en,
    input  logic running,
    output logic wake_irq,
    output logic snoop_ack
);
    logic irq_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pend  <= 1'b0;
            snoop_ack <= 1'b0;
        end else begin
            // A running core takes the interrupt itself.
            irq_pend  <= running ? 1'b0 : (irq_pend | (irq_in & accept_en));
            snoop_ack <= snoop_req & accept_en;
        end
    end

    assign wake_irq = irq_pend | irq_in;

    AST_NO_SNOOP_ACK_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_ack |-> $past(accept_en)); // R7

    AST_NO_LATCH_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_en && !irq_pend && !running) |=> !irq_pend); // R5

endmodule

// File: rtl/cidle_fsm.sv
module cidle_fsm
    import cidle_pkg::*;
#(
    parameter int unsigned PLL_CYC   = 15,
    parameter int unsigned VRAMP_CYC = 4,
    parameter int unsigned VOFF_CYC  = 40,
    parameter int unsigned TMR_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] req_lvl,
    input  logic             wake_irq,
    input  logic             l1_done,
    input  logic             l2p_done,
    input  logic             l2f_done,
    input  logic             save_done,
    input  logic             restore_done,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             exec_halt,
    output logic             clk_gate,
    output logic             pll_en,
    output logic [1:0]       vlevel,
    output logic             l1_req,
    output logic             l2p_req,
    output logic             l2f_req,
    output logic             save_req,
    output logic             restore_req,
    output logic             accept_en,
    output logic             running,
    output logic [LVL_W-1:0] status
);
    localparam logic [TMR_W-1:0] PLL_LD   = TMR_W'(PLL_CYC - 1);
    localparam logic [TMR_W-1:0] VRAMP_LD = TMR_W'(VRAMP_CYC - 1);
    localparam logic [TMR_W-1:0] VOFF_LD  = TMR_W'(VOFF_CYC - 1);

    seq_state_e       st, nxt;
    core_cond_t       cond, cond_n;
    logic [LVL_W-1:0] lvl, lvl_n;
    logic [6:1]       wk;

    // First exit step needed at or after the given stage.
    function automatic seq_state_e exit_after(input int unsigned stage,
                                              input core_cond_t c);
        if (stage <= 0 && c.volt != V_NOM) return ST_XVUP;
        if (stage <= 1 && c.pll_off)       return ST_XPLL;
        if (stage <= 2 && c.saved)         return ST_XREST;
        if (stage <= 3 && c.gated)         return ST_XUNG;
        return ST_RUN;
    endfunction

    // wk[k]: leave, or do not complete, level k
    always_comb begin
        for (int k = 1; k <= 6; k++) begin
            wk[k] = wake_irq || (req_lvl < LVL_W'(k));
        end
    end

    // Next state, condition flags and timer loads
    always_comb begin
        nxt      = st;
        cond_n   = cond;
        lvl_n    = lvl;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_RUN:   if (req_lvl != '0 && !wake_irq) nxt = ST_C1;
            ST_C1:    if (wk[1]) nxt = exit_after(0, cond);
                      else if (req_lvl >= 3'd2) nxt = ST_C2;
            ST_C2:    if (wk[2]) nxt = exit_after(0, cond);
                      else if (req_lvl >= 3'd3) nxt = ST_L1FL;
            ST_L1FL:  if (l1_done) nxt = wk[3] ? exit_after(0, cond) : ST_C3;
            ST_C3:    if (wk[3]) nxt = exit_after(0, cond);
                      else if (req_lvl >= 3'd4) nxt = ST_L2PFL;
            ST_L2PFL: if (l2p_done) nxt = wk[4] ? exit_after(0, cond) : ST_VRET;
            ST_VRET:  if (wk[4]) nxt = exit_after(0, cond);
                      else if (tmr_zero) nxt = ST_C4;
            ST_C4:    if (wk[4]) nxt = exit_after(0, cond);
                      else if (req_lvl >= 3'd5) nxt = ST_VDEEP;
            ST_VDEEP: if (wk[5]) nxt = exit_after(0, cond);
                      else if (tmr_zero) nxt = ST_C5;
            ST_C5:    if (wk[5]) nxt = exit_after(0, cond);
                      else if (req_lvl >= 3'd6) nxt = ST_SAVE;
            ST_SAVE:  if (save_done) nxt = wk[6] ? exit_after(0, cond) : ST_L2FFL;
            ST_L2FFL: if (l2f_done) nxt = wk[6] ? exit_after(0, cond) : ST_VOFF;
            ST_VOFF:  if (wk[6]) nxt = exit_after(0, cond);
                      else if (tmr_zero) nxt = ST_C6;
            ST_C6:    if (wk[6]) nxt = exit_after(0, cond);
            ST_XVUP:  if (tmr_zero) nxt = exit_after(1, cond);
            ST_XPLL:  if (tmr_zero) nxt = exit_after(2, cond);
            ST_XREST: if (restore_done) nxt = exit_after(3, cond);
            ST_XUNG:  nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase

        if (st == ST_SAVE  && nxt != ST_SAVE)  cond_n.saved = 1'b1;
        if (st == ST_XREST && nxt != ST_XREST) cond_n.saved = 1'b0;

        if (nxt != st) begin
            unique case (nxt)
                ST_RUN:   begin cond_n.halted  = 1'b0; lvl_n = 3'd0; end
                ST_C1:    begin cond_n.halted  = 1'b1; lvl_n = 3'd1; end
                ST_C2:    begin cond_n.gated   = 1'b1; lvl_n = 3'd2; end
                ST_C3:    begin cond_n.pll_off = 1'b1; lvl_n = 3'd3; end
                ST_C4:    lvl_n = 3'd4;
                ST_C5:    lvl_n = 3'd5;
                ST_C6:    lvl_n = 3'd6;
                ST_VRET:  begin cond_n.volt = V_RET;
                                tmr_load = 1'b1; tmr_val = VRAMP_LD; end
                ST_VDEEP: begin cond_n.volt = V_DEEP;
                                tmr_load = 1'b1; tmr_val = VRAMP_LD; end
                ST_VOFF:  begin cond_n.volt = V_OFF;
                                tmr_load = 1'b1; tmr_val = VOFF_LD; end
                ST_XVUP:  begin cond_n.volt = V_NOM; tmr_load = 1'b1;
                                tmr_val = (cond.volt == V_OFF) ? VOFF_LD : VRAMP_LD; end
                ST_XPLL:  begin cond_n.pll_off = 1'b0;
                                tmr_load = 1'b1; tmr_val = PLL_LD; end
                ST_XUNG:  cond_n.gated = 1'b0;
                default:  ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_RUN;
            cond <= '0;
            lvl  <= '0;
        end else begin
            st   <= nxt;
            cond <= cond_n;
            lvl  <= lvl_n;
        end
    end

    // Outputs
    always_comb begin
        exec_halt   = cond.halted;
        clk_gate    = cond.gated;
        pll_en      = !cond.pll_off;
        vlevel      = cond.volt;
        l1_req      = (st == ST_L1FL);
        l2p_req     = (st == ST_L2PFL);
        l2f_req     = (st == ST_L2FFL);
        save_req    = (st == ST_SAVE);
        restore_req = (st == ST_XREST);
        accept_en   = (st != ST_C6);
        running     = (st == ST_RUN);
        status      = lvl;
    end

    AST_GATE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate |-> exec_halt); // R10
    AST_PLL_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> clk_gate); // R10
    AST_VOLT_NEEDS_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (vlevel != 2'd0) |-> !pll_en); // R4
    AST_ONE_ENGINE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({l1_req, l2p_req, l2f_req, save_req, restore_req})); // R10
    AST_SAVED_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (vlevel == 2'd3) |-> cond.saved); // R5
    AST_PLL_BEFORE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restore_req) |-> (pll_en && vlevel == 2'd0)); // R6
    AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        status <= 3'd6); // R1

endmodule

// File: rtl/cidle_seq.sv
module cidle_seq
    import cidle_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 1000,
    parameter int unsigned PLL_LOCK_NS = 15000,
    parameter int unsigned VRAMP_NS    = 1000,
    parameter int unsigned VOFF_NS     = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] target_level,
    input  logic       irq_in,
    input  logic       snoop_req,
    input  logic       l1_flush_done,
    input  logic       l2_part_flush_done,
    input  logic       l2_full_flush_done,
    input  logic       save_done,
    input  logic       restore_done,
    output logic       exec_halt,
    output logic       clk_gate,
    output logic       pll_en,
    output logic [1:0] vlevel,
    output logic       l1_flush_req,
    output logic       l2_part_flush_req,
    output logic       l2_full_flush_req,
    output logic       save_req,
    output logic       restore_req,
    output logic       snoop_accept,
    output logic       irq_accept,
    output logic       snoop_ack,
    output logic [2:0] idle_level
);
    localparam int unsigned PLL_CYC   = ns_to_cycles(PLL_LOCK_NS, CLK_MHZ);
    localparam int unsigned VRAMP_CYC = ns_to_cycles(VRAMP_NS, CLK_MHZ);
    localparam int unsigned VOFF_CYC  = ns_to_cycles(VOFF_NS, CLK_MHZ);
    localparam int unsigned TMR_W     = $clog2(max3(PLL_CYC, VRAMP_CYC, VOFF_CYC) + 1);

    logic [LVL_W-1:0] req_lvl;
    logic             wake_irq, accept_en, running;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;

    assign req_lvl = (target_level > LVL_W'(MAX_LEVEL)) ? LVL_W'(MAX_LEVEL) : target_level;

    cidle_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .snoop_req (snoop_req),
        .accept_en (accept_en),
        .running   (running),
        .wake_irq  (wake_irq),
        .snoop_ack (snoop_ack)
    );

    cidle_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    cidle_fsm #(
        .PLL_CYC   (PLL_CYC),
        .VRAMP_CYC (VRAMP_CYC),
        .VOFF_CYC  (VOFF_CYC),
        .TMR_W     (TMR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_lvl      (req_lvl),
        .wake_irq     (wake_irq),
        .l1_done      (l1_flush_done),
        .l2p_done     (l2_part_flush_done),
        .l2f_done     (l2_full_flush_done),
        .save_done    (save_done),
        .restore_done (restore_done),
        .tmr_zero     (tmr_zero),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .exec_halt    (exec_halt),
        .clk_gate     (clk_gate),
        .pll_en       (pll_en),
        .vlevel       (vlevel),
        .l1_req       (l1_flush_req),
        .l2p_req      (l2_part_flush_req),
        .l2f_req      (l2_full_flush_req),
        .save_req     (save_req),
        .restore_req  (restore_req),
        .accept_en    (accept_en),
        .running      (running),
        .status       (idle_level)
    );

    assign snoop_accept = accept_en;
    assign irq_accept   = accept_en;

endmodule

// File: tb/cidle_seq_tb_top.sv
`timescale 1ns/1ps
module cidle_seq_tb_top;
    localparam int PLL_C = 15;  // 120 ns at 125 MHz
    localparam int VR_C  = 5;   // 40 ns
    localparam int VO_C  = 20;  // 160 ns

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] target_level = 3'd0;
    logic irq_in = 1'b0, snoop_req = 1'b0;
    logic l1_flush_done = 1'b0, l2_part_flush_done = 1'b0, l2_full_flush_done = 1'b0;
    logic save_done = 1'b0, restore_done = 1'b0;
    logic exec_halt, clk_gate, pll_en, l1_flush_req, l2_part_flush_req, l2_full_flush_req;
    logic save_req, restore_req, snoop_accept, irq_accept, snoop_ack;
    logic [1:0] vlevel;
    logic [2:0] idle_level;

    int n_chk = 0, n_err = 0, resp_dly = 1;
    bit finished = 0;

    always #4 clk = ~clk;

    cidle_seq #(.CLK_MHZ(125), .PLL_LOCK_NS(120), .VRAMP_NS(40), .VOFF_NS(160)) dut_i (
        .clk(clk), .rst_n(rst_n), .target_level(target_level), .irq_in(irq_in),
        .snoop_req(snoop_req), .l1_flush_done(l1_flush_done),
        .l2_part_flush_done(l2_part_flush_done), .l2_full_flush_done(l2_full_flush_done),
        .save_done(save_done), .restore_done(restore_done), .exec_halt(exec_halt),
        .clk_gate(clk_gate), .pll_en(pll_en), .vlevel(vlevel), .l1_flush_req(l1_flush_req),
        .l2_part_flush_req(l2_part_flush_req), .l2_full_flush_req(l2_full_flush_req),
        .save_req(save_req), .restore_req(restore_req), .snoop_accept(snoop_accept),
        .irq_accept(irq_accept), .snoop_ack(snoop_ack), .idle_level(idle_level));

    // Engine responders: done pulse resp_dly cycles after a request is seen
    initial forever begin
        @(negedge clk);
        if (l1_flush_req) begin repeat (resp_dly) @(negedge clk);
            l1_flush_done = 1; @(negedge clk); l1_flush_done = 0; end
    end
    initial forever begin
        @(negedge clk);
        if (l2_part_flush_req) begin repeat (resp_dly) @(negedge clk);
            l2_part_flush_done = 1; @(negedge clk); l2_part_flush_done = 0; end
    end
    initial forever begin
        @(negedge clk);
        if (l2_full_flush_req) begin repeat (resp_dly) @(negedge clk);
            l2_full_flush_done = 1; @(negedge clk); l2_full_flush_done = 0; end
    end
    initial forever begin
        @(negedge clk);
        if (save_req) begin repeat (resp_dly) @(negedge clk);
            save_done = 1; @(negedge clk); save_done = 0; end
    end
    initial forever begin
        @(negedge clk);
        if (restore_req) begin repeat (resp_dly) @(negedge clk);
            restore_done = 1; @(negedge clk); restore_done = 0; end
    end

    // Event monitor: negedge time stamps of output transitions
    int tnow = 0;
    int t_halt, t_gate, t_l1, t_plldn, t_l2p, t_v1, t_v2, t_save, t_l2f, t_v3, t_s6;
    int t_vnom, t_pllup, t_rest, t_ungate, t_unhalt;
    int n_l2f = 0, n_rest = 0, n_s4 = 0;
    logic p_halt = 0, p_gate = 0, p_pll = 1, p_l1 = 0, p_l2p = 0, p_save = 0;
    logic p_l2f = 0, p_rest = 0;
    logic [1:0] p_v = 0;
    logic [2:0] p_s = 0;
    initial forever begin
        @(negedge clk);
        tnow++;
        if (rst_n) begin
            if (exec_halt && !p_halt) t_halt = tnow;
            if (!exec_halt && p_halt) t_unhalt = tnow;
            if (clk_gate && !p_gate) t_gate = tnow;
            if (!clk_gate && p_gate) t_ungate = tnow;
            if (!pll_en && p_pll) t_plldn = tnow;
            if (pll_en && !p_pll) t_pllup = tnow;
            if (l1_flush_req && !p_l1) t_l1 = tnow;
            if (l2_part_flush_req && !p_l2p) t_l2p = tnow;
            if (save_req && !p_save) t_save = tnow;
            if (l2_full_flush_req && !p_l2f) begin t_l2f = tnow; n_l2f++; end
            if (restore_req && !p_rest) begin t_rest = tnow; n_rest++; end
            if (vlevel != p_v) begin
                if (vlevel == 2'd1) t_v1 = tnow;
                if (vlevel == 2'd2) t_v2 = tnow;
                if (vlevel == 2'd3) t_v3 = tnow;
                if (vlevel == 2'd0) t_vnom = tnow;
            end
            if (idle_level != p_s && idle_level == 3'd6) t_s6 = tnow;
            if (idle_level != p_s && idle_level == 3'd4) n_s4++;
        end
        p_halt = exec_halt; p_gate = clk_gate; p_pll = pll_en; p_l1 = l1_flush_req;
        p_l2p = l2_part_flush_req; p_save = save_req; p_l2f = l2_full_flush_req;
        p_rest = restore_req; p_v = vlevel; p_s = idle_level;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected {halt, gate, pll_en, vlevel, snoop_accept, irq_accept} per resting level
    function automatic logic [6:0] exp_outs(input int lvl);
        logic [1:0] v;
        v = (lvl >= 6) ? 2'd3 : (lvl == 5) ? 2'd2 : (lvl == 4) ? 2'd1 : 2'd0;
        return {lvl >= 1, lvl >= 2, lvl < 3, v, lvl != 6, lvl != 6};
    endfunction

    function automatic logic [6:0] act_outs();
        return {exec_halt, clk_gate, pll_en, vlevel, snoop_accept, irq_accept};
    endfunction

    task automatic wait_status(input int k, input int lim, input string tag);
        int n = 0;
        while (int'(idle_level) != k && n < lim) begin @(negedge clk); n++; end
        check(int'(idle_level) == k, tag, int'(idle_level), k);
    endtask

    task automatic check_outs(input int lvl, input string tag);
        check(act_outs() == exp_outs(lvl), tag, int'(act_outs()), int'(exp_outs(lvl)));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check_outs(0, "R1 reset outputs");
        check(idle_level == 3'd0 && !l1_flush_req && !save_req && !restore_req &&
              !l2_part_flush_req && !l2_full_flush_req, "R1 reset level/requests",
              int'(idle_level), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Directed descent to each level and back
        for (int k = 1; k <= 6; k++) begin
            target_level = 3'(k);
            wait_status(k, 400, "R9 reach level");
            repeat (3) @(negedge clk);
            case (k)
                1, 2:    check_outs(k, "R2 C1/C2 outputs");
                3:       check_outs(k, "R3 C3 outputs");
                4, 5:    check_outs(k, "R4 C4/C5 outputs");
                default: check_outs(k, "R5 C6 outputs");
            endcase
            if (k == 3) check(t_l1 < t_plldn && t_gate < t_l1, "R3 flush before PLL stop",
                              t_plldn, t_l1 + 1);
            if (k == 6) begin
                check(t_halt < t_gate && t_gate < t_l1 && t_l1 < t_plldn && t_plldn < t_l2p &&
                      t_l2p < t_v1 && t_v1 < t_v2 && t_v2 < t_save && t_save < t_l2f &&
                      t_l2f < t_v3, "R5 entry order", t_v3, t_l2f + 1);
                check(t_v2 - t_v1 == VR_C + 1, "R4 retention ramp", t_v2 - t_v1, VR_C + 1);
                check(t_s6 - t_v3 == VO_C, "R5 off ramp", t_s6 - t_v3, VO_C);
            end
            target_level = 3'd0;
            wait_status(0, 400, "R9 back to run");
            @(negedge clk);
            check_outs(0, "R6 run outputs after exit");
            if (k == 3) check(t_ungate - t_pllup == PLL_C, "R6 PLL lock wait from C3",
                              t_ungate - t_pllup, PLL_C);
            if (k == 6) begin
                check(t_pllup - t_vnom == VO_C, "R6 voltage recover", t_pllup - t_vnom, VO_C);
                check(t_rest - t_pllup == PLL_C, "R6 PLL before restore", t_rest - t_pllup, PLL_C);
                check(t_ungate > t_rest, "R6 ungate after restore", t_ungate, t_rest + 1);
                check(t_unhalt - t_ungate == 1, "R6 resume after ungate", t_unhalt - t_ungate, 1);
            end
        end

        // R7 snoop in C3 answered, in C6 ignored
        target_level = 3'd3; wait_status(3, 400, "R7 reach C3");
        snoop_req = 1; @(negedge clk); snoop_req = 0;
        check(snoop_ack == 1'b1, "R7 snoop ack in C3", int'(snoop_ack), 1);
        @(negedge clk);
        check(idle_level == 3'd3, "R7 level kept after snoop", int'(idle_level), 3);
        target_level = 3'd6; wait_status(6, 400, "R7 reach C6");
        snoop_req = 1; @(negedge clk); snoop_req = 0;
        check(snoop_ack == 1'b0, "R7 no snoop ack in C6", int'(snoop_ack), 0);
        check(idle_level == 3'd6, "R7 stays in C6", int'(idle_level), 6);

        // R9 shallower target while idle: through C0, then back in
        target_level = 3'd2;
        wait_status(0, 400, "R9 shallower request passes C0");
        wait_status(2, 400, "R9 re-entry to C2");
        check_outs(2, "R9 C2 outputs after re-entry");

        // R9 interrupt wake from C4, re-entry with target kept
        target_level = 3'd4; wait_status(4, 400, "R9 reach C4");
        irq_in = 1; @(negedge clk); irq_in = 0;
        wait_status(0, 400, "R9 irq wake to C0");
        wait_status(4, 400, "R9 irq re-entry to C4");
        target_level = 3'd0; wait_status(0, 400, "R9 run");

        // R8 abort during save handshake
        begin
            int l2f0, rest0;
            resp_dly = 3; l2f0 = n_l2f; rest0 = n_rest;
            target_level = 3'd6;
            while (!save_req) @(negedge clk);
            target_level = 3'd0;
            wait_status(0, 600, "R8 save abort returns to C0");
            repeat (2) @(negedge clk);
            check(n_l2f == l2f0, "R8 no full flush after abort", n_l2f - l2f0, 0);
            check(n_rest == rest0 + 1, "R8 restore after saved abort", n_rest - rest0, 1);
        end

        // R8 abort during retention ramp
        begin
            int s40;
            resp_dly = 1; s40 = n_s4;
            target_level = 3'd4;
            while (vlevel != 2'd1) @(negedge clk);
            target_level = 3'd0;
            wait_status(0, 400, "R8 ramp abort returns to C0");
            check(n_s4 == s40, "R8 C4 never reported", n_s4 - s40, 0);
            check_outs(0, "R8 outputs after ramp abort");
        end

        // R1 target 7 acts as 6
        target_level = 3'd7; wait_status(6, 400, "R1 target 7 clamps to C6");
        target_level = 3'd0; wait_status(0, 400, "R1 run");

        // Random targets, engine delays and interrupts
        for (int i = 0; i < 30; i++) begin
            int tgt, lv;
            tgt = int'($urandom_range(0, 7));
            lv = (tgt > 6) ? 6 : tgt;
            resp_dly = int'($urandom_range(0, 3));
            target_level = 3'(tgt);
            wait_status(lv, 600, "R9 random settle");
            repeat (2) @(negedge clk);
            check_outs(lv, "R10 random level outputs");
            if (lv != 0 && $urandom_range(0, 2) == 0) begin
                irq_in = 1; @(negedge clk); irq_in = 0;
                wait_status(0, 600, "R9 random irq wake");
                wait_status(lv, 600, "R9 random re-entry");
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule